// File: doc/BRIEF.md
# Indirect Forwarding Entry Table

This block holds a table of 68-bit forwarding entries behind a small memory-mapped register bus. Software never addresses an entry directly: it goes through an index register and a window of three 32-bit data words. To fetch an entry, software writes its index with the commit bit clear, and the entry then appears in the window. To store an entry, software fills the window words and then writes the index with the commit bit set, which moves all 68 bits into the table in a single cycle.

The window lists the entry's words most-significant first. The lowest window offset carries the four top entry bits, and the highest offset carries entry bits 31:0. The two-bit entry kind field is decoded from the window and reported when the index register is read. A clear command, and every reset, sweeps the table one entry per cycle and returns every entry to the free kind. A busy flag stays up for the whole sweep, and table accesses wait until the sweep is done.

Top module: `fwd_tbl_top`

## Requirements
- R1: A read at offset 0x00 returns the major revision parameter in bits 15:8, the minor revision parameter in bits 7:0, and zeros in bits 31:16. Writes to this offset change nothing.
- R2: After reset the busy flag (bit 0 of offset 0x08) reads 1. Once it falls, every entry reads back as all zeros, which is the free kind.
- R3: A write to offset 0x20 with bit 31 clear loads entry number bits 27:0 into the window, where offsets 0x34, 0x38 and 0x3C can read it.
- R4: A write to offset 0x20 with bit 31 set stores all three staged window words into entry number bits 27:0 together. Other entries keep their contents.
- R5: Window word order is reversed. Offset 0x34 holds entry bits 67:64 in its bits 3:0, and its bits 31:4 always read 0. Offset 0x38 holds entry bits 63:32. Offset 0x3C holds entry bits 31:0.
- R6: A read of offset 0x20 returns the last written entry number in bits 27:0 and zeros in bits 31:30. Bits 29:28 give the window's kind field (entry bits 61:60, which is offset 0x38 bits 29:28), encoded as 0 free, 1 address, 2 VLAN, 3 VLAN plus address.
- R7: An entry number at or above the ENTRIES parameter is out of range. A commit to it changes no entry, even one whose number matches in the low address bits. A load from it fills the window with zeros.
- R8: Writing 1 to bit 30 of offset 0x08 starts a sweep that zeroes one entry per cycle. The busy flag stays 1 until the last entry is zeroed. A clear command given while busy is ignored.
- R9: While busy, accesses to offsets 0x20, 0x34, 0x38 and 0x3C are not acknowledged until the sweep ends. Offsets 0x00 and 0x08 are still served with no delay.
- R10: An access is accepted on a clock edge where bus_req is high, bus_ack is low and the access is not stalled. bus_ack is high for exactly the one cycle after acceptance, with bus_rdata valid in that cycle.
- R11: Reads of unmapped offsets return 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also starts a table sweep |
| bus_req | input | 1 | Access request, held until bus_ack |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | One-cycle acknowledge |
| bus_rdata | output | 32 | Read data, valid with bus_ack |

## Verification
The bench builds the table with ENTRIES set to 12, which is not a power of two. With that depth, numbers 12 to 15 fit the four-bit internal address yet are out of range, and number 16 aliases entry 0 in the low bits. Both cases become reachable. The small depth also keeps each sweep at twelve cycles, so the stall on table accesses, and the ID and control reads served during a sweep, can be watched in full. Non-default revision values (2 and 7) check that the ID register follows the parameters.

// File: rtl/fwd_tbl_pkg.sv
`timescale 1ns/1ps
package fwd_tbl_pkg;
  typedef enum logic [1:0] {
    KIND_FREE      = 2'd0,
    KIND_ADDR      = 2'd1,
    KIND_VLAN      = 2'd2,
    KIND_VLAN_ADDR = 2'd3
  } ent_kind_e;

  localparam int ENT_BITS  = 68;
  localparam int WORD_W    = 32;
  localparam int HI_BITS   = ENT_BITS - 2 * WORD_W;
  localparam int NUM_W     = 28;
  localparam int KIND_LSB  = 28;  // entry bit 60 seen inside the middle window word

  localparam int OFS_ID    = 'h00;
  localparam int OFS_CTRL  = 'h08;
  localparam int OFS_IDX   = 'h20;
  localparam int OFS_WHI   = 'h34;
  localparam int OFS_WMID  = 'h38;
  localparam int OFS_WLO   = 'h3C;

  localparam int CLEAR_BIT  = 30;
  localparam int BUSY_BIT   = 0;
  localparam int COMMIT_BIT = 31;

  function automatic ent_kind_e kind_of(input logic [WORD_W-1:0] mid_word);
    return ent_kind_e'(mid_word[KIND_LSB +: 2]);
  endfunction
endpackage

// File: rtl/fwd_tbl_ram.sv
`timescale 1ns/1ps
module fwd_tbl_ram #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 68,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  // one write port, one registered read port: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/fwd_tbl_sweep.sv
`timescale 1ns/1ps
module fwd_tbl_sweep #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1;
      ptr  <= '0;
    end else if (busy) begin
      if (ptr == LAST) busy <= 1'b0;
      else             ptr  <= ptr + AW'(1);
    end else if (start) begin
      busy <= 1'b1;
      ptr  <= '0;
    end
  end

  AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && ptr != LAST) |=> (busy && ptr == $past(ptr) + AW'(1))); // R8
  AST_SWEEP_END: assert property (@(posedge clk) disable iff (rst)
    (busy && ptr == LAST) |=> !busy); // R8
endmodule

// File: rtl/fwd_tbl_top.sv
`timescale 1ns/1ps
module fwd_tbl_top
  import fwd_tbl_pkg::*;
#(
  parameter int          ENTRIES   = 1024,
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  VER_MAJOR = 8'h01,
  parameter logic [7:0]  VER_MINOR = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ack,
  output logic [31:0]       bus_rdata
);
  localparam int               AW    = $clog2(ENTRIES);
  localparam logic [NUM_W-1:0] LIMIT = NUM_W'(ENTRIES);
  localparam logic [AW:0]      DEPTH = (AW+1)'(ENTRIES);

  // register decode
  logic hit_id, hit_ctrl, hit_idx, hit_whi, hit_wmid, hit_wlo, hit_tbl;
  assign hit_id   = bus_addr == ADDR_W'(OFS_ID);
  assign hit_ctrl = bus_addr == ADDR_W'(OFS_CTRL);
  assign hit_idx  = bus_addr == ADDR_W'(OFS_IDX);
  assign hit_whi  = bus_addr == ADDR_W'(OFS_WHI);
  assign hit_wmid = bus_addr == ADDR_W'(OFS_WMID);
  assign hit_wlo  = bus_addr == ADDR_W'(OFS_WLO);
  assign hit_tbl  = hit_idx | hit_whi | hit_wmid | hit_wlo;

  logic          sweep_busy;
  logic [AW-1:0] sweep_ptr;
  logic          stall, accept, wr_acc;
  assign stall  = hit_tbl && sweep_busy;
  assign accept = bus_req && !bus_ack && !stall;
  assign wr_acc = accept && bus_we;

  logic [NUM_W-1:0] req_num;
  logic             req_oor;
  assign req_num = bus_wdata[NUM_W-1:0];
  assign req_oor = req_num >= LIMIT;

  // staging window and index
  logic [HI_BITS-1:0] win_hi;
  logic [WORD_W-1:0]  win_mid, win_lo;
  logic [NUM_W-1:0]   num_q;
  logic               load_pend, load_oor;
  ent_kind_e          win_kind;
  assign win_kind = kind_of(win_mid);

  // table storage and its single write path
  logic                ram_we, commit_we, clear_go;
  logic [AW-1:0]       ram_waddr;
  logic [ENT_BITS-1:0] ram_wdata, ram_q;

  assign commit_we = wr_acc && hit_idx && bus_wdata[COMMIT_BIT] && !req_oor;
  assign clear_go  = wr_acc && hit_ctrl && bus_wdata[CLEAR_BIT];
  assign ram_we    = sweep_busy || commit_we;
  assign ram_waddr = sweep_busy ? sweep_ptr : req_num[AW-1:0];
  assign ram_wdata = sweep_busy ? '0 : {win_hi, win_mid, win_lo};

  fwd_tbl_ram #(.DEPTH(ENTRIES), .WIDTH(ENT_BITS), .AW(AW)) ram_i (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (req_num[AW-1:0]),
    .rdata (ram_q)
  );

  fwd_tbl_sweep #(.DEPTH(ENTRIES), .AW(AW)) sweep_i (
    .clk   (clk),
    .rst   (rst),
    .start (clear_go),
    .busy  (sweep_busy),
    .ptr   (sweep_ptr)
  );

  // read mux
  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (hit_id)   rd_val = {16'h0000, VER_MAJOR, VER_MINOR};
    if (hit_ctrl) rd_val[BUSY_BIT] = sweep_busy;
    if (hit_idx)  rd_val = {2'b00, win_kind, num_q};
    if (hit_whi)  rd_val = {{(WORD_W-HI_BITS){1'b0}}, win_hi};
    if (hit_wmid) rd_val = win_mid;
    if (hit_wlo)  rd_val = win_lo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
      win_hi    <= '0;
      win_mid   <= '0;
      win_lo    <= '0;
      num_q     <= '0;
      load_pend <= 1'b0;
      load_oor  <= 1'b0;
    end else begin
      bus_ack   <= accept;
      load_pend <= 1'b0;
      if (accept) bus_rdata <= bus_we ? 32'h0 : rd_val;
      if (wr_acc) begin
        if (hit_whi)  win_hi  <= bus_wdata[HI_BITS-1:0];
        if (hit_wmid) win_mid <= bus_wdata;
        if (hit_wlo)  win_lo  <= bus_wdata;
        if (hit_idx) begin
          num_q <= req_num;
          if (!bus_wdata[COMMIT_BIT]) begin
            load_pend <= 1'b1;
            load_oor  <= req_oor;
          end
        end
      end
      if (load_pend) begin
        {win_hi, win_mid, win_lo} <= load_oor ? '0 : ram_q;
      end
    end
  end

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack); // R10
  AST_STALL_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack && hit_tbl && sweep_busy) |=> !bus_ack); // R9
  AST_COMMIT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (ram_we && !sweep_busy) |-> ({1'b0, ram_waddr} < DEPTH)); // R7
  AST_SWEEP_WRITES_FREE: assert property (@(posedge clk) disable iff (rst)
    (ram_we && sweep_busy) |-> (ram_wdata == '0)); // R8
endmodule

// File: tb/fwd_tbl_top_tb_top.sv
`timescale 1ns/1ps
module fwd_tbl_top_tb_top;
  localparam int N = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ack;
  logic [31:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  fwd_tbl_top #(.ENTRIES(N), .ADDR_W(8), .VER_MAJOR(8'h02), .VER_MINOR(8'h07)) dut_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [7:0] addr, input logic [31:0] wd,
                      output logic [31:0] rd, output int lat);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = wd;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!bus_ack && lat < 2000);
    rd = bus_rdata;
    bus_req = 1'b0;
    if (lat >= 2000) begin
      n_bad++;
      $display("FAIL R10 actual=no_ack expected=ack");
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] r; int l;
    xfer(1'b1, a, d, r, l);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    int l;
    xfer(1'b0, a, 32'h0, d, l);
  endtask

  task automatic wait_idle();
    logic [31:0] r;
    for (int i = 0; i < 100; i++) begin
      rd(8'h08, r);
      if (r[0] == 1'b0) break;
    end
  endtask

  task automatic check_entry(input string tag, input int idx, input logic [3:0] hi,
                             input logic [31:0] mid, input logic [31:0] lo);
    logic [31:0] r;
    wr(8'h20, 32'(idx));
    rd(8'h34, r); chk(tag, r, {28'h0, hi});
    rd(8'h38, r); chk(tag, r, mid);
    rd(8'h3C, r); chk(tag, r, lo);
  endtask

  task automatic t_reset();
    logic [31:0] r; int l;
    chk("R10 idle ack", {31'h0, bus_ack}, 32'h0);
    xfer(1'b0, 8'h08, 32'h0, r, l);
    chk("R2 busy after reset", r, 32'h1);
    wait_idle();
    check_entry("R2 entry0 free", 0, 4'h0, 32'h0, 32'h0);
    check_entry("R2 last entry free", N - 1, 4'h0, 32'h0, 32'h0);
  endtask

  task automatic t_id();
    logic [31:0] r; int l;
    xfer(1'b0, 8'h00, 32'h0, r, l);
    chk("R1 id value", r, 32'h0000_0207);
    chk("R10 latency", 32'(l), 32'd1);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, r);
    chk("R1 id after write", r, 32'h0000_0207);
  endtask

  task automatic t_commit_load();
    logic [31:0] r;
    wr(8'h34, 32'hFFFF_FFF5);
    rd(8'h34, r);
    chk("R5 hi word upper zero", r, 32'h0000_0005);
    wr(8'h38, 32'h1234_5678);
    wr(8'h3C, 32'hCAFE_BABE);
    wr(8'h20, 32'h8000_0003);
    wr(8'h34, 32'h0000_000A);
    wr(8'h38, 32'h2000_0001);
    wr(8'h3C, 32'h0BAD_F00D);
    wr(8'h20, 32'h8000_0007);
    check_entry("R3 R4 entry3", 3, 4'h5, 32'h1234_5678, 32'hCAFE_BABE);
    rd(8'h20, r);
    chk("R6 index read kind addr", r, 32'h1000_0003);
    check_entry("R4 R5 entry7", 7, 4'hA, 32'h2000_0001, 32'h0BAD_F00D);
    rd(8'h20, r);
    chk("R6 index read kind vlan", r, 32'h2000_0007);
    check_entry("R4 neighbour untouched", 4, 4'h0, 32'h0, 32'h0);
  endtask

  task automatic t_kinds();
    logic [31:0] r;
    for (int k = 0; k < 4; k++) begin
      wr(8'h38, 32'(k) << 28);
      rd(8'h20, r);
      chk("R6 kind field", {30'h0, r[29:28]}, 32'(k));
    end
  endtask

  task automatic t_oor();
    wr(8'h34, 32'h0000_000F);
    wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h3C, 32'hFFFF_FFFF);
    wr(8'h20, 32'h8000_000C);
    wr(8'h20, 32'h8000_0010);
    check_entry("R7 load beyond end", 12, 4'h0, 32'h0, 32'h0);
    check_entry("R7 alias of entry0", 0, 4'h0, 32'h0, 32'h0);
    check_entry("R7 index 15 zeros", 15, 4'h0, 32'h0, 32'h0);
  endtask

  task automatic t_clear();
    logic [31:0] r; int l;
    wr(8'h08, 32'h4000_0000);
    xfer(1'b0, 8'h08, 32'h0, r, l);
    chk("R8 busy during sweep", r, 32'h1);
    chk("R9 ctrl not stalled", 32'(l), 32'd1);
    wr(8'h08, 32'h4000_0000);
    xfer(1'b0, 8'h00, 32'h0, r, l);
    chk("R9 id during sweep", r, 32'h0000_0207);
    chk("R9 id not stalled", 32'(l), 32'd1);
    xfer(1'b1, 8'h20, 32'h0000_0003, r, l);
    chk("R9 table access stalled", 32'(l > 1), 32'd1);
    rd(8'h08, r);
    chk("R8 busy cleared", r, 32'h0);
    check_entry("R8 entry3 freed", 3, 4'h0, 32'h0, 32'h0);
    check_entry("R8 entry7 freed", 7, 4'h0, 32'h0, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] r;
    wr(8'h44, 32'hDEAD_BEEF);
    rd(8'h44, r);
    chk("R11 unmapped reads zero", r, 32'h0);
    rd(8'h08, r);
    chk("R11 no side effect", r, 32'h0);
    @(negedge clk);
    chk("R10 ack single cycle", {31'h0, bus_ack}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_id();
    t_commit_load();
    t_kinds();
    t_oor();
    t_clear();
    t_unmapped();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule